// File: doc/BRIEF.md
# Blanking-Interval Ancillary Packet Formatter

The formatter turns the data recovered from one video line during vertical blanking into an ancillary packet for a 10-bit 4:2:2 serial video stream. Payload is first loaded into a staging buffer. A start pulse then captures the header fields: data ID, secondary ID, the video line number and three status flags. The packet goes out on the luma bus one word per cycle, but only in cycles that follow a high horizontal-blanking qualifier. It stalls while that qualifier is low.

For sliced data, the same byte sequence is also copied into a byte FIFO that a host drains at its own pace. Before the first byte is written, the formatter checks that the FIFO has room for the whole packet. If it does not, the FIFO copy is skipped and a sticky overflow flag is raised. The packet is never cut short.

A raw variant carries unsliced 10-bit samples behind a four-word lead-in. It has no header, checksum or fill, and it bypasses the FIFO.

Top module: `vbi_anc_formatter`

## Requirements
- R1: A sliced packet starts with the three words 000h, 3FFh, 3FFh. A raw packet starts with 000h, 3FFh, 3FFh, 180h.
- R2: Sliced words 4, 5 and 6 carry the data ID, the secondary ID and the word count. Each is a byte B on y_out[9:2], with y_out[1:0]=0. B[5:0] is the value, B[6] is the XOR of B[5:0] (even parity), and B[7] is the inverse of B[6].
- R3: The word count equals ceil((L+3)/4), where L is the payload length in bytes. Word 7 carries line[7:0]. Word 8 carries a byte with bits 1:0 = line[9:8], bit 2 = match-2 flag, bit 3 = match-1 flag, bit 4 = error flag, and bits 7:5 = 0.
- R4: The L payload bytes follow. The next byte is the modulo-256 sum of every byte from the data ID through the last payload byte. Zero bytes then pad the run from word 7 onward to exactly 4×count bytes.
- R5: y_valid is high for exactly one cycle per packet word. It is high only in the cycle after hblank was high, and words advance only on such cycles. y_out is 0 whenever y_valid is low.
- R6: A raw packet is the four-word lead-in followed by the L staged 10-bit samples unchanged. Nothing else follows, and the FIFO is not touched.
- R7: When admitted, every byte of a sliced packet enters the FIFO in stream order, taken from y_out[9:2]. fifo_data shows the oldest byte whenever fifo_empty is low. A cycle with fifo_rd high removes that byte.
- R8: If free FIFO space is smaller than 6+4×count bytes at start, the whole sliced packet is kept out of the FIFO. fifo_ovf then rises and stays high until reset. The stream copy is still sent.
- R9: A start while busy is ignored. Payload writes while busy, or in the cycle of start, are ignored. Writes beyond MAX_PAY entries are ignored.
- R10: After reset, y_valid, y_out, busy, fifo_count and fifo_ovf are 0 and fifo_empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pay_wr | input | 1 | Append pay_data to the staging buffer |
| pay_data | input | 10 | Payload byte (bits 7:0) or raw sample |
| start | input | 1 | Begin a packet with the captured header |
| start_raw | input | 1 | Packet at start is raw |
| hdr_did | input | 6 | Data ID value |
| hdr_sdid | input | 6 | Secondary ID value |
| hdr_line | input | 10 | Video line number |
| hdr_err | input | 1 | Data-error flag |
| hdr_match1 | input | 1 | First filter-match flag |
| hdr_match2 | input | 1 | Second filter-match flag |
| hblank | input | 1 | Horizontal blanking qualifier |
| y_out | output | 10 | Luma bus packet word |
| y_valid | output | 1 | y_out holds a packet word |
| busy | output | 1 | Packet in progress |
| fifo_rd | input | 1 | Pop one FIFO byte |
| fifo_data | output | 8 | Oldest FIFO byte |
| fifo_empty | output | 1 | FIFO holds no byte |
| fifo_count | output | 10 | FIFO occupancy in bytes |
| fifo_ovf | output | 1 | Sticky packet-dropped flag |

## Verification
The bench covers three length corner cases, each tied to the failure it would expose:
- A zero-length payload, where a wrong count or fill formula would emit the wrong number of pad bytes.
- Lengths that land on either side of a word boundary, where an off-by-one on the checksum position would either swallow a payload byte or place the checksum inside the fill.
- A staging buffer overfilled past its limit, where a missing guard would lengthen the packet.

Broken stalling, such as a design that advances while blanking is low, is exposed by an irregular hblank pattern: the stream then loses or repeats words. The FIFO is filled until one packet no longer fits. A design that truncates would leave a partial packet whose bytes misalign every later read. A design that never sets the flag would show fifo_ovf low. Drains that overlap writes catch faulty count arithmetic.

// File: rtl/vbi_anc_pkg.sv
// Shared constants and helpers for the ancillary packet formatter.
// Assumes a 10-bit luma bus where header bytes occupy bits 9:2.
package vbi_anc_pkg;

    localparam logic [9:0] LEAD_LO  = 10'h000;
    localparam logic [9:0] LEAD_HI  = 10'h3FF;
    localparam logic [9:0] RAW_MARK = 10'h180;
    localparam int         NW       = 6;   // width of the word-count field
    localparam int         TW       = 16;  // width used for byte arithmetic

    // Builds a header byte: value in 5:0, even parity in 6, its inverse in 7
    function automatic logic [7:0] par_byte(input logic [5:0] v);
        return {~(^v), ^v, v};
    endfunction

endpackage

// File: rtl/vbi_pay_buf.sv
// Staging buffer for one line of payload.
// Appends entries in order, up to MAX_PAY, until cleared.
// Reads are combinational by address. Writes past the limit are dropped.
module vbi_pay_buf #(
    parameter int MAX_PAY = 64,
    parameter int DW      = 10,
    localparam int AW     = (MAX_PAY > 1) ? $clog2(MAX_PAY) : 1,
    localparam int CW     = $clog2(MAX_PAY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          clr,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [MAX_PAY];
    logic          room;

    assign room    = count < CW'(MAX_PAY);
    assign rd_data = mem[rd_addr];

    // Fill level: clears at end of packet, grows on each accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)            count <= '0;
        else if (clr)          count <= '0;
        else if (wr_en && room) count <= count + 1'b1;
    end

    // Storage write at the current fill position
    always_ff @(posedge clk) begin
        if (wr_en && room && !clr) mem[count[AW-1:0]] <= wr_data;
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(MAX_PAY));

    a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(MAX_PAY) && !clr) |=> count == CW'(MAX_PAY));

endmodule

// File: rtl/vbi_pkt_fifo.sv
// Byte FIFO that holds formatted packets for host retrieval.
// DEPTH must be a power of two. The output is show-ahead.
// The writer guarantees room, because admission is decided per packet upstream.
module vbi_pkt_fifo #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_byte,
    input  logic          rd_en,
    output logic [7:0]    rd_byte,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic [CW-1:0] free
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          rd_ok, wr_ok;

    assign empty   = (count == '0);
    assign free    = CW'(DEPTH) - count;
    assign rd_ok   = rd_en && !empty;
    assign wr_ok   = wr_en && (count < CW'(DEPTH));
    assign rd_byte = mem[rp];

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; count <= '0;
        end else begin
            if (wr_ok) wp <= wp + 1'b1;
            if (rd_ok) rp <= rp + 1'b1;
            count <= count + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wr_byte;
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (count < CW'(DEPTH)));

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> $stable(count));

endmodule

// File: rtl/vbi_pkt_seq.sv
// Packet sequencer.
// Captures the header at start and walks a word index, emitting one word per
// cycle when hblank is high. Builds the checksum on the fly and mirrors sliced
// bytes into the FIFO when the packet was admitted.
// Assumes MAX_PAY keeps the word count within six bits.
module vbi_pkt_seq
    import vbi_anc_pkg::*;
#(
    parameter int MAX_PAY    = 64,
    parameter int FIFO_DEPTH = 512,
    localparam int AW  = (MAX_PAY > 1) ? $clog2(MAX_PAY) : 1,
    localparam int CW  = $clog2(MAX_PAY + 1),
    localparam int FCW = $clog2(FIFO_DEPTH) + 1,
    localparam int IW  = $clog2(MAX_PAY + 16)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           raw,
    input  logic [5:0]     did,
    input  logic [5:0]     sdid,
    input  logic [9:0]     line,
    input  logic           err,
    input  logic           m1,
    input  logic           m2,
    input  logic           hblank,
    input  logic [CW-1:0]  pay_len,
    input  logic [9:0]     pay_data,
    input  logic [FCW-1:0] fifo_free,
    output logic [AW-1:0]  pay_addr,
    output logic           pay_clr,
    output logic           busy,
    output logic [9:0]     y_out,
    output logic           y_valid,
    output logic           fifo_wr,
    output logic [7:0]     fifo_byte,
    output logic           ovf
);

    logic          raw_q, err_q, m1_q, m2_q, keep_q, hdr_q;
    logic [5:0]    did_q, sdid_q;
    logic [9:0]    line_q;
    logic [IW-1:0] len_q, idx_q, last_q;
    logic [NW-1:0] nn_q;
    logic [7:0]    sum_q, byte_v;
    logic [9:0]    word;
    logic [IW-1:0] pay_off;
    logic          in_sum, is_hdr, step, accept, at_last;
    logic [TW-1:0] nn_t, need_t, last_t;

    assign step    = busy && hblank;
    assign accept  = start && !busy;
    assign at_last = (idx_q == last_q);
    assign pay_clr = step && at_last;
    assign fifo_wr = step && keep_q && !raw_q;
    assign fifo_byte = word[9:2];

    // Sizing of the packet about to start
    always_comb begin
        nn_t   = (TW'(pay_len) + TW'(6)) >> 2;
        need_t = TW'(6) + (nn_t << 2);
        last_t = raw ? (TW'(3) + TW'(pay_len)) : (TW'(5) + (nn_t << 2));
    end

    // Word selection for the current index
    always_comb begin
        byte_v  = 8'h00;
        in_sum  = 1'b0;
        is_hdr  = 1'b0;
        pay_off = idx_q - (raw_q ? IW'(4) : IW'(8));
        if (idx_q < IW'(3)) begin
            word = (idx_q == '0) ? LEAD_LO : LEAD_HI;
        end else if (raw_q) begin
            word = (idx_q == IW'(3)) ? RAW_MARK : pay_data;
        end else begin
            case (idx_q)
                IW'(3): byte_v = par_byte(did_q);
                IW'(4): byte_v = par_byte(sdid_q);
                IW'(5): byte_v = par_byte(nn_q);
                IW'(6): byte_v = line_q[7:0];
                IW'(7): byte_v = {3'b000, err_q, m1_q, m2_q, line_q[9:8]};
                default: begin
                    if (idx_q < IW'(8) + len_q)       byte_v = pay_data[7:0];
                    else if (idx_q == IW'(8) + len_q) byte_v = sum_q;
                    else                               byte_v = 8'h00;
                end
            endcase
            in_sum = idx_q < IW'(8) + len_q;
            is_hdr = idx_q < IW'(6);
            word   = {byte_v, 2'b00};
        end
    end

    assign pay_addr = pay_off[AW-1:0];

    // Header capture at an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0; did_q <= '0; sdid_q <= '0; line_q <= '0;
            err_q <= 1'b0; m1_q <= 1'b0; m2_q <= 1'b0;
            len_q <= '0; nn_q <= '0; last_q <= '0; keep_q <= 1'b0;
        end else if (accept) begin
            raw_q  <= raw;   did_q <= did;  sdid_q <= sdid; line_q <= line;
            err_q  <= err;   m1_q  <= m1;   m2_q   <= m2;
            len_q  <= IW'(pay_len);
            nn_q   <= nn_t[NW-1:0];
            last_q <= last_t[IW-1:0];
            keep_q <= !raw && (TW'(fifo_free) >= need_t);
        end
    end

    // Sticky drop flag for packets that did not fit
    always_ff @(posedge clk) begin
        if (!rst_n)                                       ovf <= 1'b0;
        else if (accept && !raw && TW'(fifo_free) < need_t) ovf <= 1'b1;
    end

    // Walk through the packet and drive the registered luma bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; idx_q <= '0; sum_q <= '0;
            y_out <= '0; y_valid <= 1'b0; hdr_q <= 1'b0;
        end else begin
            if (accept) begin
                busy <= 1'b1; idx_q <= '0; sum_q <= '0;
            end
            if (step) begin
                y_out   <= word;
                y_valid <= 1'b1;
                hdr_q   <= is_hdr && !raw_q && (idx_q >= IW'(3));
                idx_q   <= idx_q + 1'b1;
                if (!raw_q && in_sum && idx_q >= IW'(3)) sum_q <= sum_q + byte_v;
                if (at_last) busy <= 1'b0;
            end else begin
                y_out   <= '0;
                y_valid <= 1'b0;
                hdr_q   <= 1'b0;
            end
        end
    end

    a_r5_valid_after_hblank: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> $past(hblank));

    a_r5_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !y_valid |-> (y_out == '0));

    a_r2_parity: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_q |-> (y_out[8] == ^y_out[7:2]) && (y_out[9] != y_out[8]) && (y_out[1:0] == 2'b00));

    a_r5_last_word: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> y_valid);

    a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(start));

endmodule

// File: rtl/vbi_anc_formatter.sv
// Top level of the ancillary packet formatter.
// Connects the payload staging buffer, the packet sequencer and the packet FIFO.
// Payload writes are accepted only while idle and not in a start cycle.
module vbi_anc_formatter #(
    parameter int MAX_PAY    = 64,
    parameter int FIFO_DEPTH = 512,
    localparam int AW  = (MAX_PAY > 1) ? $clog2(MAX_PAY) : 1,
    localparam int CW  = $clog2(MAX_PAY + 1),
    localparam int FCW = $clog2(FIFO_DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pay_wr,
    input  logic [9:0]     pay_data,
    input  logic           start,
    input  logic           start_raw,
    input  logic [5:0]     hdr_did,
    input  logic [5:0]     hdr_sdid,
    input  logic [9:0]     hdr_line,
    input  logic           hdr_err,
    input  logic           hdr_match1,
    input  logic           hdr_match2,
    input  logic           hblank,
    output logic [9:0]     y_out,
    output logic           y_valid,
    output logic           busy,
    input  logic           fifo_rd,
    output logic [7:0]     fifo_data,
    output logic           fifo_empty,
    output logic [FCW-1:0] fifo_count,
    output logic           fifo_ovf
);

    logic           buf_wr, buf_clr, f_wr;
    logic [AW-1:0]  buf_addr;
    logic [9:0]     buf_data;
    logic [CW-1:0]  buf_count;
    logic [7:0]     f_byte;
    logic [FCW-1:0] f_free;

    assign buf_wr = pay_wr && !busy && !start;

    vbi_pay_buf #(.MAX_PAY(MAX_PAY), .DW(10)) i_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(buf_wr), .wr_data(pay_data),
        .clr(buf_clr), .rd_addr(buf_addr), .rd_data(buf_data), .count(buf_count)
    );

    vbi_pkt_seq #(.MAX_PAY(MAX_PAY), .FIFO_DEPTH(FIFO_DEPTH)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .raw(start_raw),
        .did(hdr_did), .sdid(hdr_sdid), .line(hdr_line),
        .err(hdr_err), .m1(hdr_match1), .m2(hdr_match2), .hblank(hblank),
        .pay_len(buf_count), .pay_data(buf_data), .fifo_free(f_free),
        .pay_addr(buf_addr), .pay_clr(buf_clr), .busy(busy),
        .y_out(y_out), .y_valid(y_valid), .fifo_wr(f_wr), .fifo_byte(f_byte),
        .ovf(fifo_ovf)
    );

    vbi_pkt_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(f_wr), .wr_byte(f_byte),
        .rd_en(fifo_rd), .rd_byte(fifo_data), .empty(fifo_empty),
        .count(fifo_count), .free(f_free)
    );

    a_r9_busy_blocks_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !buf_clr) |=> $stable(buf_count));

    a_r6_raw_no_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && start_raw) |=> !f_wr);

endmodule

// File: tb/test_vbi_anc_formatter.sv
`timescale 1ns/1ps
module test_vbi_anc_formatter;

    localparam int MAXP  = 64;
    localparam int DEPTH = 512;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       pay_wr = 0, start = 0, start_raw = 0, hblank = 0, fifo_rd = 0;
    logic [9:0] pay_data = '0, hdr_line = '0;
    logic [5:0] hdr_did = '0, hdr_sdid = '0;
    logic       hdr_err = 0, hdr_match1 = 0, hdr_match2 = 0;
    logic [9:0] y_out;
    logic       y_valid, busy, fifo_empty, fifo_ovf;
    logic [7:0] fifo_data;
    logic [9:0] fifo_count;

    always #2.5 clk = ~clk;

    vbi_anc_formatter i_vbi_anc_formatter (
        .clk(clk), .rst_n(rst_n), .pay_wr(pay_wr), .pay_data(pay_data),
        .start(start), .start_raw(start_raw), .hdr_did(hdr_did), .hdr_sdid(hdr_sdid),
        .hdr_line(hdr_line), .hdr_err(hdr_err), .hdr_match1(hdr_match1),
        .hdr_match2(hdr_match2), .hblank(hblank), .y_out(y_out), .y_valid(y_valid),
        .busy(busy), .fifo_rd(fifo_rd), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_count(fifo_count), .fifo_ovf(fifo_ovf)
    );

    int checks = 0, fails = 0, cyc = 0, hb_mode = 0;
    bit started = 0, finished = 0;

    // Reference model state
    logic [9:0] mq[$];        // staged payload
    logic [9:0] wq[$];        // pending stream words
    int         tq[$];        // requirement tag for each pending word
    logic [7:0] fq[$];        // FIFO contents
    bit m_busy = 0, m_raw = 0, m_keep = 0, m_ovf = 0, ev = 0;
    logic [9:0] ew = '0;
    int etag = 5;

    function automatic logic [7:0] pb(input logic [5:0] v);
        return {~(^v), ^v, v};
    endfunction

    // Build the expected word list for a packet accepted at this edge
    task automatic build();
        int len, nn;
        logic [7:0] cs, b;
        len = mq.size();
        wq.delete(); tq.delete();
        wq.push_back(10'h000); tq.push_back(1);
        wq.push_back(10'h3FF); tq.push_back(1);
        wq.push_back(10'h3FF); tq.push_back(1);
        if (start_raw) begin
            wq.push_back(10'h180); tq.push_back(6);
            for (int i = 0; i < len; i++) begin wq.push_back(mq[i]); tq.push_back(6); end
            m_keep = 0;
        end else begin
            nn = (len + 3 + 3) / 4;   // R3: ceil((len+3)/4)
            cs = 8'h00;
            b = pb(hdr_did);  cs += b; wq.push_back({b, 2'b00}); tq.push_back(2);
            b = pb(hdr_sdid); cs += b; wq.push_back({b, 2'b00}); tq.push_back(2);
            b = pb(6'(nn));   cs += b; wq.push_back({b, 2'b00}); tq.push_back(3);
            b = hdr_line[7:0]; cs += b; wq.push_back({b, 2'b00}); tq.push_back(3);
            b = {3'b000, hdr_err, hdr_match1, hdr_match2, hdr_line[9:8]};
            cs += b; wq.push_back({b, 2'b00}); tq.push_back(3);
            for (int i = 0; i < len; i++) begin
                b = mq[i][7:0]; cs += b; wq.push_back({b, 2'b00}); tq.push_back(4);
            end
            wq.push_back({cs, 2'b00}); tq.push_back(4);
            for (int i = 0; i < 4 * nn - len - 3; i++) begin wq.push_back(10'h000); tq.push_back(4); end
            m_keep = (DEPTH - fq.size()) >= (6 + 4 * nn);
            if (!m_keep) m_ovf = 1;   // R8
        end
        m_raw = start_raw;
    endtask

    // Cycle model, evaluated on inputs that were driven at the previous falling edge
    always @(posedge clk) begin
        bit b0, pop_ok;
        started = 1;
        if (!rst_n) begin
            mq.delete(); wq.delete(); tq.delete(); fq.delete();
            m_busy = 0; m_ovf = 0; ev = 0; ew = '0; m_keep = 0;
        end else begin
            b0 = m_busy;
            pop_ok = fifo_rd && fq.size() > 0;
            if (pop_ok) void'(fq.pop_front());
            if (b0 && hblank) begin
                ev = 1; ew = wq.pop_front(); etag = tq.pop_front();
                if (m_keep && !m_raw) fq.push_back(ew[9:2]);
                if (wq.size() == 0) begin m_busy = 0; mq.delete(); end
            end else begin
                ev = 0; ew = '0; etag = 5;
            end
            if (!b0 && start) begin build(); m_busy = 1; end
            if (!b0 && !start && pay_wr && mq.size() < MAXP) mq.push_back(pay_data);
        end
    end

    task automatic chk(input bit ok, input int tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Compare outputs against the model away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            int rt;
            rt = rst_n ? 5 : 10;   // R10 while in reset, R5 otherwise
            chk(y_valid == ev, rt, "y_valid", y_valid, ev);
            chk(y_out == ew, rst_n ? etag : 10, "y_out", y_out, ew);
            chk(busy == m_busy, rst_n ? 9 : 10, "busy", busy, m_busy);
            chk(fifo_count == 10'(fq.size()), rst_n ? 7 : 10, "fifo_count", fifo_count, fq.size());
            chk(fifo_empty == (fq.size() == 0), 7, "fifo_empty", fifo_empty, fq.size() == 0);
            if (fq.size() > 0) chk(fifo_data == fq[0], 7, "fifo_data", fifo_data, fq[0]);
            chk(fifo_ovf == m_ovf, rst_n ? 8 : 10, "fifo_ovf", fifo_ovf, m_ovf);
        end
    end

    task automatic step();
        @(negedge clk);
        cyc++;
        hblank = (hb_mode == 0) ? 1'b1 : ((cyc % 5) != 1 && (cyc % 7) != 3);
    endtask

    task automatic load(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            pay_wr = 1; pay_data = 10'((seed * 37 + i * 11) & 10'h3FF);
            step();
        end
        pay_wr = 0;
    endtask

    task automatic fire(input bit rawm, input int line);
        start = 1; start_raw = rawm;
        hdr_did = 6'(line * 3 + 1); hdr_sdid = 6'(line + 5); hdr_line = 10'(line);
        hdr_err = line[0]; hdr_match1 = line[1]; hdr_match2 = line[2];
        step();
        start = 0;
    endtask

    task automatic finish_pkt();
        step();
        while (m_busy) step();
        step();
    endtask

    initial begin
        hblank = 1;
        repeat (3) step();
        rst_n = 1;                               // R10 checked while held in reset
        step();
        // R1 R2 R3 R4 R7: sliced, continuous blanking, assorted lengths
        load(5, 1);  fire(0, 21);  finish_pkt();
        load(0, 2);  fire(0, 518); finish_pkt();
        load(1, 3);  fire(0, 7);   finish_pkt();
        load(4, 4);  fire(0, 1023); finish_pkt();
        // R5: stalls under an irregular blanking pattern
        hb_mode = 1;
        load(13, 5); fire(0, 300); finish_pkt();
        // R6: raw packet
        load(6, 6);  fire(1, 40);  finish_pkt();
        load(0, 7);  fire(1, 41);  finish_pkt();
        hb_mode = 0;
        // R9: start and payload writes while busy are ignored
        load(3, 8);  fire(0, 12);
        fire(1, 13);
        load(2, 9);
        finish_pkt();
        // R9: overfill the staging buffer
        load(MAXP + 2, 10); fire(0, 99); finish_pkt();
        // R8: fill FIFO until a packet no longer fits
        for (int k = 0; k < 7; k++) begin load(MAXP, 11 + k); fire(0, 100 + k); finish_pkt(); end
        // R7: drain while another packet is written
        fifo_rd = 1;
        load(9, 30); fire(0, 200); finish_pkt();
        while (fq.size() > 0) step();
        fifo_rd = 0;
        load(2, 31); fire(0, 201); finish_pkt();
        repeat (3) step();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL R5 watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule